// File: doc/BRIEF.md
# Host Register and Memory Slave

This block is a slave on a 16-bit host bus. The host uses an active-low write strobe, an active-low read strobe, a 16-bit word address and a shared 16-bit bidirectional data bus. Behind that bus the block decodes four regions:

- a fixed identification word
- a lock word whose bits are cleared by writing ones
- a bank of general-purpose read/write registers
- a word-addressed memory

A write completes at the clock edge where the write strobe is low. A read request is registered at the clock edge where it is seen. The addressed word is then driven onto the bus for the following cycle, so the host samples it one clock after presenting the address. At all other times the block leaves the bus at high impedance.

The reset input is asynchronous and active low. Inside the block its release is synchronized to the clock. Reset restores every register to its defined value but leaves the memory contents alone.

Top module: `hostreg_slave`

## Requirements
- R1: The word at address 0x0000 always reads 0x5A03 (low byte 0x03, high byte 0x5A), and writes to it change nothing.
- R2: The lock word at address 0x0100 comes out of reset as 0xFFFF. A write clears every bit whose written data bit is 1 and keeps every bit whose written data bit is 0.
- R3: Addresses 0x1000 to 0x10FF hold 256 independent 16-bit read/write registers, one per address, each 0x0000 after reset.
- R4: Addresses 0x4000 to 0x4FFF map a 4096 x 16 read/write memory whose contents survive a reset.
- R5: A write takes effect at the rising clock edge where wr_n is low, using the address and data present in that cycle. Back-to-back write cycles each complete.
- R6: A read request (rd_n low, wr_n high) seen at a rising edge makes the block drive the addressed word for the whole next cycle. The block does not drive during the request cycle itself.
- R7: Outside the cycle that follows a read request, the block leaves host_data at high impedance, so a value driven by the host is not disturbed.
- R8: Reads from addresses outside the four regions return 0x0000, and writes to them change no register, memory word or lock bit.
- R9: When wr_n and rd_n are both low, the cycle is a write and the block does not drive the bus in the cycle after.
- R10: Asserting rst_n low returns the lock word to 0xFFFF and every array register to 0x0000 after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized inside |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| addr | input | 16 | Word address |
| host_data | inout | 16 | Shared data bus: write data in, read data out |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 256 array registers and 4096 memory words. Because this configuration is small, every array register and every memory word can be written with an arithmetic pattern and read back in one run. The bench also reads all 256 array entries after reset, steps the lock word through several clear masks, and probes the bus with a host-driven pattern in non-read cycles to show that the block stays off the bus. The unmapped addresses it tries sit just past the edges of each region. This is where a decode slip would show up.

// File: rtl/hostreg_pkg.sv
`timescale 1ns/1ps
package hostreg_pkg;

  typedef enum logic [2:0] {
    RGN_NONE = 3'd0,
    RGN_ID   = 3'd1,
    RGN_LOCK = 3'd2,
    RGN_ARR  = 3'd3,
    RGN_MEM  = 3'd4
  } rgn_e;

endpackage

// File: rtl/hostreg_decode.sv
`timescale 1ns/1ps
module hostreg_decode
  import hostreg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] ID_ADDR   = 16'h0000,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h0100,
  parameter logic [ADDR_W-1:0] ARR_BASE  = 16'h1000,
  parameter int                ARR_DEPTH = 256,
  parameter logic [ADDR_W-1:0] MEM_BASE  = 16'h4000,
  parameter int                MEM_DEPTH = 4096,
  localparam int               ARR_IW    = $clog2(ARR_DEPTH),
  localparam int               MEM_IW    = $clog2(MEM_DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              rgn,
  output logic [ARR_IW-1:0] arr_idx,
  output logic [MEM_IW-1:0] mem_idx
);

  localparam logic [ADDR_W-1:0] ARR_TAG = ARR_BASE >> ARR_IW;
  localparam logic [ADDR_W-1:0] MEM_TAG = MEM_BASE >> MEM_IW;

  logic hit_arr;
  logic hit_mem;

  assign hit_arr = ((addr >> ARR_IW) == ARR_TAG);
  assign hit_mem = ((addr >> MEM_IW) == MEM_TAG);

  always_comb begin
    if (addr == ID_ADDR) begin
      rgn = RGN_ID;
    end else if (addr == LOCK_ADDR) begin
      rgn = RGN_LOCK;
    end else if (hit_arr) begin
      rgn = RGN_ARR;
    end else if (hit_mem) begin
      rgn = RGN_MEM;
    end else begin
      rgn = RGN_NONE;
    end
  end

  assign arr_idx = addr[ARR_IW-1:0];
  assign mem_idx = addr[MEM_IW-1:0];

endmodule

// File: rtl/hostreg_regfile.sv
`timescale 1ns/1ps
module hostreg_regfile
  import hostreg_pkg::*;
#(
  parameter int          DATA_W    = 16,
  parameter int          ARR_DEPTH = 256,
  parameter logic [7:0]  ID_REV    = 8'h03,
  parameter logic [7:0]  ID_CHIP   = 8'h5A,
  localparam int         ARR_IW    = $clog2(ARR_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic              rd_req,
  input  rgn_e              rgn,
  input  logic [ARR_IW-1:0] arr_idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_q,
  output logic [DATA_W-1:0] lock_val
);

  localparam logic [DATA_W-1:0] ID_WORD = DATA_W'({ID_CHIP, ID_REV});

  logic [DATA_W-1:0] lock_q;
  logic [DATA_W-1:0] lock_nx;
  logic              lock_en;
  logic [ARR_DEPTH-1:0] arr_we;
  logic [DATA_W-1:0] arr_rd [ARR_DEPTH];
  logic [DATA_W-1:0] rd_nx;

  // lock word: write-one-to-clear
  assign lock_en = wr_req && (rgn == RGN_LOCK);

  always_comb begin
    lock_nx = lock_q & ~wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= '1;
    end else if (lock_en) begin
      lock_q <= lock_nx;
    end
  end

  // array write enables
  always_comb begin
    arr_we = '0;
    if (wr_req && (rgn == RGN_ARR)) begin
      arr_we[arr_idx] = 1'b1;
    end
  end

  for (genvar g = 0; g < ARR_DEPTH; g++) begin : g_ent
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (arr_we[g]) begin
        q <= wdata;
      end
    end
    assign arr_rd[g] = q;
  end

  // read select, registered on a read request
  always_comb begin
    unique case (rgn)
      RGN_ID:   rd_nx = ID_WORD;
      RGN_LOCK: rd_nx = lock_q;
      RGN_ARR:  rd_nx = arr_rd[arr_idx];
      default:  rd_nx = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
    end else if (rd_req) begin
      rd_q <= rd_nx;
    end
  end

  assign lock_val = lock_q;

endmodule

// File: rtl/hostreg_mem.sv
`timescale 1ns/1ps
module hostreg_mem #(
  parameter int  DATA_W    = 16,
  parameter int  MEM_DEPTH = 4096,
  localparam int MEM_IW    = $clog2(MEM_DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [MEM_IW-1:0] idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_q
);

  logic [DATA_W-1:0] store [MEM_DEPTH];

  // storage has no reset so it keeps contents across reset
  always_ff @(posedge clk) begin
    if (we) begin
      store[idx] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rd_q <= store[idx];
    end
  end

endmodule

// File: rtl/hostreg_slave.sv
`timescale 1ns/1ps
module hostreg_slave
  import hostreg_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 16,
  parameter logic [ADDR_W-1:0] ID_ADDR   = 16'h0000,
  parameter logic [ADDR_W-1:0] LOCK_ADDR = 16'h0100,
  parameter logic [ADDR_W-1:0] ARR_BASE  = 16'h1000,
  parameter int                ARR_DEPTH = 256,
  parameter logic [ADDR_W-1:0] MEM_BASE  = 16'h4000,
  parameter int                MEM_DEPTH = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic [ADDR_W-1:0] addr,
  inout  wire  [DATA_W-1:0] host_data
);

  localparam int ARR_IW = $clog2(ARR_DEPTH);
  localparam int MEM_IW = $clog2(MEM_DEPTH);

  // reset: asserted asynchronously, released through two flops
  logic rst_meta;
  logic rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sn   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sn   <= rst_meta;
    end
  end

  logic              wr_req;
  logic              rd_req;
  rgn_e              rgn;
  logic [ARR_IW-1:0] arr_idx;
  logic [MEM_IW-1:0] mem_idx;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] reg_rd;
  logic [DATA_W-1:0] mem_rd;
  logic [DATA_W-1:0] lock_val;
  logic [DATA_W-1:0] rd_word;
  logic              drive_q;
  logic              drive_nx;
  logic              from_mem_q;
  logic              from_mem_nx;

  // write wins over read when both strobes are low
  assign wr_req = !wr_n;
  assign rd_req = !rd_n && wr_n;
  assign wdata  = host_data;

  hostreg_decode #(
    .ADDR_W(ADDR_W), .ID_ADDR(ID_ADDR), .LOCK_ADDR(LOCK_ADDR),
    .ARR_BASE(ARR_BASE), .ARR_DEPTH(ARR_DEPTH),
    .MEM_BASE(MEM_BASE), .MEM_DEPTH(MEM_DEPTH)
  ) u_dec (
    .addr(addr), .rgn(rgn), .arr_idx(arr_idx), .mem_idx(mem_idx)
  );

  hostreg_regfile #(
    .DATA_W(DATA_W), .ARR_DEPTH(ARR_DEPTH)
  ) u_regs (
    .clk(clk), .rst_n(rst_sn), .wr_req(wr_req), .rd_req(rd_req),
    .rgn(rgn), .arr_idx(arr_idx), .wdata(wdata),
    .rd_q(reg_rd), .lock_val(lock_val)
  );

  hostreg_mem #(
    .DATA_W(DATA_W), .MEM_DEPTH(MEM_DEPTH)
  ) u_mem (
    .clk(clk),
    .we(wr_req && (rgn == RGN_MEM)),
    .re(rd_req && (rgn == RGN_MEM)),
    .idx(mem_idx), .wdata(wdata), .rd_q(mem_rd)
  );

  // bus drive control
  always_comb begin
    drive_nx    = rd_req;
    from_mem_nx = (rgn == RGN_MEM);
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      drive_q <= 1'b0;
    end else begin
      drive_q <= drive_nx;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      from_mem_q <= 1'b0;
    end else if (rd_req) begin
      from_mem_q <= from_mem_nx;
    end
  end

  assign rd_word   = from_mem_q ? mem_rd : reg_rd;
  assign host_data = drive_q ? rd_word : {DATA_W{1'bz}};

endmodule

// File: rtl/hostreg_chk.sv
`timescale 1ns/1ps
module hostreg_chk #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_n,
  input logic              rd_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              drive_q,
  input logic [DATA_W-1:0] rd_word,
  input logic [DATA_W-1:0] lock_val
);

  logic rd_cyc;
  logic lock_wr;
  logic unmapped;

  assign rd_cyc   = !rd_n && wr_n;
  assign lock_wr  = !wr_n && (addr == 16'h0100);
  assign unmapped = (addr != 16'h0000) && (addr != 16'h0100) &&
                    (addr[15:8] != 8'h10) && (addr[15:12] != 4'h4);

  assert_id_word_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && addr == 16'h0000) |=> (rd_word == 16'h5A03));

  assert_lock_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |=> (lock_val == ($past(lock_val) & ~$past(wdata))));

  assert_lock_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_wr |=> $stable(lock_val));

  assert_drive_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cyc |=> drive_q);

  assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_cyc |=> !drive_q);

  assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_cyc && unmapped) |=> (rd_word == '0));

  assert_write_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && !rd_n) |=> !drive_q);

endmodule

bind hostreg_slave hostreg_chk u_chk (
  .clk(clk), .rst_n(rst_sn), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
  .wdata(wdata), .drive_q(drive_q), .rd_word(rd_word), .lock_val(lock_val)
);

// File: tb/tb_hostreg_slave.sv
`timescale 1ns/100ps
module tb_hostreg_slave;

  logic        clk;
  logic        rst_n;
  logic        wr_n;
  logic        rd_n;
  logic [15:0] addr;
  logic        tb_drv;
  logic [15:0] tb_val;
  wire  [15:0] bus;

  int n_chk;
  int n_fail;
  int cyc;

  localparam logic [15:0] PROBE = 16'h3CC3;

  assign bus = tb_drv ? tb_val : 16'hzzzz;

  hostreg_slave dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n),
    .addr(addr), .host_data(bus)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; tb_val = d; tb_drv = 1'b1; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; tb_drv = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk);
    addr = a; rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    d = bus;
  endtask

  task automatic rd_chk(input string req, input logic [15:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  // host drives a pattern in an idle cycle; block must not disturb it
  task automatic probe(input string req);
    @(negedge clk);
    tb_val = PROBE; tb_drv = 1'b1;
    #1;
    check(req, bus, PROBE);
    tb_drv = 1'b0;
  endtask

  function automatic logic [15:0] arr_pat(input int i);
    return 16'((i * 16'h03B1) + 16'h1234);
  endfunction

  function automatic logic [15:0] mem_pat(input int i);
    return 16'((i * 16'h9E37) ^ 16'h5A5A);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        finish_run();
      end
    end
  end

  initial begin
    logic [15:0] lock_exp;
    logic [15:0] v;
    n_chk = 0; n_fail = 0;
    wr_n = 1'b1; rd_n = 1'b1; addr = '0; tb_drv = 1'b0; tb_val = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state
    probe("R7 idle after reset");
    rd_chk("R1 id after reset", 16'h0000, 16'h5A03);
    rd_chk("R10 lock reset value", 16'h0100, 16'hFFFF);
    for (int i = 0; i < 256; i++) rd_chk("R3 array reset zero", 16'h1000 + 16'(i), 16'h0000);

    // id ignores writes
    wr(16'h0000, 16'h1234);
    probe("R7 no drive after write");
    rd_chk("R1 id after write", 16'h0000, 16'h5A03);

    // lock W1C
    lock_exp = 16'hFFFF;
    wr(16'h0100, 16'h0000);
    rd_chk("R2 lock after zero write", 16'h0100, lock_exp);
    wr(16'h0100, 16'h00F0); lock_exp &= ~16'h00F0;
    rd_chk("R2 lock partial clear", 16'h0100, lock_exp);
    wr(16'h0100, 16'h8001); lock_exp &= ~16'h8001;
    rd_chk("R2 lock second clear", 16'h0100, lock_exp);
    wr(16'h0100, 16'hFFFF);
    rd_chk("R2 lock full clear", 16'h0100, 16'h0000);

    // R6: block stays off the bus during the request cycle itself
    @(negedge clk);
    addr = 16'h0000; rd_n = 1'b0; tb_val = PROBE; tb_drv = 1'b1;
    #1;
    check("R6 no drive in request cycle", bus, PROBE);
    tb_drv = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    check("R6 data in next cycle", bus, 16'h5A03);

    // array sweep with back-to-back writes (R5)
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      addr = 16'h1000 + 16'(i); tb_val = arr_pat(i); tb_drv = 1'b1; wr_n = 1'b0;
      @(negedge clk);
    end
    wr_n = 1'b1; tb_drv = 1'b0;
    for (int i = 0; i < 256; i++) rd_chk("R3 R5 array readback", 16'h1000 + 16'(i), arr_pat(i));

    // memory sweep
    for (int i = 0; i < 4096; i++) wr(16'h4000 + 16'(i), mem_pat(i));
    for (int i = 0; i < 4096; i++) rd_chk("R4 memory readback", 16'h4000 + 16'(i), mem_pat(i));

    // unmapped reads and writes
    rd_chk("R8 unmapped 0001", 16'h0001, 16'h0000);
    rd_chk("R8 unmapped 00FF", 16'h00FF, 16'h0000);
    rd_chk("R8 unmapped 0101", 16'h0101, 16'h0000);
    rd_chk("R8 unmapped 0FFF", 16'h0FFF, 16'h0000);
    rd_chk("R8 unmapped 1100", 16'h1100, 16'h0000);
    rd_chk("R8 unmapped 3FFF", 16'h3FFF, 16'h0000);
    rd_chk("R8 unmapped 5000", 16'h5000, 16'h0000);
    rd_chk("R8 unmapped FFFF", 16'hFFFF, 16'h0000);
    wr(16'h1100, 16'hDEAD);
    wr(16'h5000, 16'hBEEF);
    wr(16'h0200, 16'hFFFF);
    rd_chk("R8 array 0 untouched", 16'h1000, arr_pat(0));
    rd_chk("R8 memory 0 untouched", 16'h4000, mem_pat(0));
    rd_chk("R8 unmapped stays zero", 16'h1100, 16'h0000);

    // both strobes low: write wins
    @(negedge clk);
    addr = 16'h1005; tb_val = 16'h7777; tb_drv = 1'b1; wr_n = 1'b0; rd_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b1; tb_val = PROBE;
    #1;
    check("R9 no drive after both low", bus, PROBE);
    tb_drv = 1'b0;
    rd_chk("R9 write taken", 16'h1005, 16'h7777);

    // reset mid-run
    wr(16'h1007, 16'hBEEF);
    do_reset();
    rd_chk("R10 array cleared", 16'h1007, 16'h0000);
    rd_chk("R10 array 5 cleared", 16'h1005, 16'h0000);
    rd_chk("R10 lock restored", 16'h0100, 16'hFFFF);
    rd_chk("R4 memory kept across reset", 16'h4005, mem_pat(5));
    rd_chk("R4 memory top kept", 16'h4FFF, mem_pat(4095));
    rd(16'h0000, v);
    check("R1 id after reset", v, 16'h5A03);
    probe("R7 idle at end");

    finish_run();
  end

endmodule